// File: doc/BRIEF.md
# Serial Bit-Rate and Frame Tick Generator

This block produces the timing strobes that pace a serial port. From the peripheral clock it derives an oversampling enable, a bit-period tick and a frame tick. The divider chain is a four-way prescaler (divide by 1, 4, 16 or 64), followed by an 8-bit rate counter that divides by the rate value plus one. That gives one oversampling pulse every prescale × (rate + 1) clocks. A divide-by-32 stage turns oversampling pulses into bit ticks, and a divide-by-10 stage turns bit ticks into frame ticks. The frame tick is the per-character step that moves data through the transmit and receive FIFOs.

A select input switches the time base to an external clock pin. That pin is synchronized, and each of its rising edges becomes one oversampling pulse. The prescale and rate inputs are then ignored.

Configuration inputs are levels held by the surrounding register file. A one-cycle write strobe accompanies every configuration change and restarts all counters. As a result, no partial period computed under the old setting reaches the outputs.

Top module: `sbr_tick_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, all three outputs are low after that edge. After the release edge, the chain starts from zero exactly as it does after a configuration write (R6).
- R2: The prescale code `cfg_presc` selects the divisor 1, 4, 16 or 64 for codes 0, 1, 2 and 3.
- R3: In internal mode, `os_en` rises once every N = prescale × (`cfg_rate` + 1) clock cycles and is high for one cycle when N > 1. When N = 1 it stays high.
- R4: `bit_tick` is a one-cycle pulse. It is high in the cycle after every 32nd `os_en` pulse, so its period is 32·N.
- R5: `frame_tick` is a one-cycle pulse. It is high in the cycle after every 10th `bit_tick`, so its period is 320·N.
- R6: A `cfg_wr` pulse clears all counters and outputs at that edge. Counting the write edge as W, the first `os_en` follows at edge W+N, the first `bit_tick` at W+32·N+1 and the first `frame_tick` at W+320·N+2, with none earlier.
- R7: With `cfg_ext_sel` = 1, each rising edge of `ext_clk` (after a two-flop synchronizer) yields exactly one `os_en` pulse, whatever the prescale and rate values are. A steady `ext_clk` yields none.
- R8: With `cfg_ext_sel` = 0, activity on `ext_clk` has no effect on the output periods.
- R9: The largest rate value, 255, gives an oversampling period of 256 × prescale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_presc | input | 2 | Prescale code: 0→/1, 1→/4, 2→/16, 3→/64 |
| cfg_rate | input | 8 | Rate value; divides by value + 1 |
| cfg_ext_sel | input | 1 | 1 selects the external clock as time base |
| cfg_wr | input | 1 | One-cycle strobe on any configuration write; restarts counters |
| ext_clk | input | 1 | External clock, asynchronous to `clk` |
| os_en | output | 1 | 32x oversampling enable pulse |
| bit_tick | output | 1 | One pulse per bit period |
| frame_tick | output | 1 | One pulse per 10-bit frame |

## Verification
The divider is tried with the prescale and rate pairs (0,0), (1,2), (2,0), (3,1) and (0,255). The pair (0,0) is the degenerate case where the enable stays high. The other pairs separate prescaler faults from rate-counter faults, because a swapped or off-by-one term changes the measured period differently for each pair. A write issued part-way through a period tells a true restart apart from a divider that merely picks up the new value, since only a restart gives first-pulse offsets of exactly N, 32N+1 and 320N+2 cycles. External mode is run with a 6-cycle clock while prescale and rate are set to their maximum, and then with the pin held steady. Internal mode is run with the pin toggling, which shows the time-base selection works in both directions.

// File: rtl/sbr_pkg.sv
// Package: shared constants and helpers for the serial bit-rate tick generator.
// Assumes: prescale codes are 2 bits; divisors are powers of four.
package sbr_pkg;

    localparam int unsigned PRE_CODE_W = 2;
    localparam int unsigned PRE_MAX    = 64;
    localparam int unsigned PRE_W      = $clog2(PRE_MAX);

    typedef enum logic [PRE_CODE_W-1:0] {
        PRE_DIV1  = 2'd0,
        PRE_DIV4  = 2'd1,
        PRE_DIV16 = 2'd2,
        PRE_DIV64 = 2'd3
    } pre_code_e;

    // Terminal count (divisor minus one) for a prescale code.
    function automatic logic [PRE_W-1:0] pre_last(input logic [PRE_CODE_W-1:0] code);
        logic [PRE_W:0] div;
        div = (PRE_W+1)'(1) << (2 * code);
        return PRE_W'(div - 1'b1);
    endfunction

endpackage

// File: rtl/sbr_ext_sync.sv
// Module: sbr_ext_sync
// Brings the asynchronous external clock into the clk domain and emits a
// one-cycle pulse for each rising edge seen at the synchronizer output.
// Assumes: ext_clk high and low phases each last at least two clk cycles.
module sbr_ext_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    output logic rise
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the external level through the synchronizer and keep the prior output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], ext_clk};
            last_q <= sync_q[STAGES-1];
        end
    end

    // Rising edge of the synchronized level.
    always_comb rise = sync_q[STAGES-1] & ~last_q;

    // R7: an edge pulse never lasts two cycles.
    assert_rise_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/sbr_os_div.sv
// Module: sbr_os_div
// Produces the oversampling enable. In internal mode a prescaler (1/4/16/64)
// feeds a rate counter dividing by rate+1. In external mode each synchronized
// rising edge is forwarded instead.
// Assumes: configuration changes only together with a restart.
module sbr_os_div
    import sbr_pkg::*;
#(
    parameter int unsigned RATE_W = 8
) (
    input  logic                  clk,
    input  logic                  restart,
    input  logic [PRE_CODE_W-1:0] presc,
    input  logic [RATE_W-1:0]     rate,
    input  logic                  ext_sel,
    input  logic                  ext_rise,
    output logic                  os_en
);

    logic [PRE_W-1:0]  pre_cnt;
    logic [RATE_W-1:0] rate_cnt;
    logic [PRE_W-1:0]  pre_term;
    logic              pre_pulse;
    logic              int_pulse;

    // Decode the prescale terminal count and the stage strobes.
    always_comb begin
        pre_term  = pre_last(presc);
        pre_pulse = (pre_cnt >= pre_term);
        int_pulse = pre_pulse && (rate_cnt >= rate);
    end

    // Advance the prescaler and rate counters; register the chosen source.
    always_ff @(posedge clk) begin
        if (restart) begin
            pre_cnt  <= '0;
            rate_cnt <= '0;
            os_en    <= 1'b0;
        end else begin
            os_en <= ext_sel ? ext_rise : int_pulse;
            if (pre_pulse) begin
                pre_cnt  <= '0;
                rate_cnt <= (rate_cnt >= rate) ? '0 : rate_cnt + 1'b1;
            end else begin
                pre_cnt  <= pre_cnt + 1'b1;
            end
        end
    end

    // R2: the prescaler never runs past the selected divisor.
    assert_pre_bound_R2: assert property (@(posedge clk) disable iff (restart)
        pre_cnt <= pre_term);

    // R3: for a divide ratio above one the enable is a single-cycle pulse.
    assert_os_single_R3: assert property (@(posedge clk) disable iff (restart)
        (os_en && !ext_sel && (pre_term != '0 || rate != '0)) |=> !os_en);

    // R7: in external mode every enable comes from a detected edge.
    assert_ext_source_R7: assert property (@(posedge clk) disable iff (restart)
        (os_en && ext_sel && $past(ext_sel)) |-> $past(ext_rise));

endmodule

// File: rtl/sbr_pulse_div.sv
// Module: sbr_pulse_div
// Counts input pulses and emits a registered pulse one cycle after every
// DIV-th input pulse.
// Assumes: DIV >= 2.
module sbr_pulse_div #(
    parameter int unsigned DIV = 32
) (
    input  logic clk,
    input  logic restart,
    input  logic pulse_in,
    output logic pulse_out
);

    localparam int unsigned CNT_W = $clog2(DIV);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt;

    // Count input pulses and flag the terminal one.
    always_ff @(posedge clk) begin
        if (restart) begin
            cnt       <= '0;
            pulse_out <= 1'b0;
        end else begin
            pulse_out <= pulse_in && (cnt == LAST);
            if (pulse_in) begin
                cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            end
        end
    end

    // R4/R5: an output pulse always follows an input pulse.
    assert_out_follows_in_R4: assert property (@(posedge clk) disable iff (restart)
        pulse_out |-> $past(pulse_in));

endmodule

// File: rtl/sbr_tick_gen.sv
// Module: sbr_tick_gen (top)
// Serial timing chain: oversampling enable -> bit tick (/OS_RATIO) ->
// frame tick (/FRAME_BITS). Restart on reset or any configuration write.
// Assumes: cfg_* levels are stable between cfg_wr strobes.
module sbr_tick_gen
    import sbr_pkg::*;
#(
    parameter int unsigned RATE_W     = 8,
    parameter int unsigned OS_RATIO   = 32,
    parameter int unsigned FRAME_BITS = 10,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PRE_CODE_W-1:0] cfg_presc,
    input  logic [RATE_W-1:0]     cfg_rate,
    input  logic                  cfg_ext_sel,
    input  logic                  cfg_wr,
    input  logic                  ext_clk,
    output logic                  os_en,
    output logic                  bit_tick,
    output logic                  frame_tick
);

    logic restart;
    logic ext_rise;

    // Counters restart on reset or on a configuration write.
    always_comb restart = !rst_n || cfg_wr;

    sbr_ext_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_clk (ext_clk),
        .rise    (ext_rise)
    );

    sbr_os_div #(.RATE_W(RATE_W)) u_os (
        .clk      (clk),
        .restart  (restart),
        .presc    (cfg_presc),
        .rate     (cfg_rate),
        .ext_sel  (cfg_ext_sel),
        .ext_rise (ext_rise),
        .os_en    (os_en)
    );

    sbr_pulse_div #(.DIV(OS_RATIO)) u_bit (
        .clk       (clk),
        .restart   (restart),
        .pulse_in  (os_en),
        .pulse_out (bit_tick)
    );

    sbr_pulse_div #(.DIV(FRAME_BITS)) u_frame (
        .clk       (clk),
        .restart   (restart),
        .pulse_in  (bit_tick),
        .pulse_out (frame_tick)
    );

    // R6: the cycle after a configuration write is quiet on every output.
    assert_quiet_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_wr) |-> (!os_en && !bit_tick && !frame_tick));

    // R5: a frame tick is always preceded by a bit tick.
    assert_frame_on_bit_R5: assert property (@(posedge clk) disable iff (restart)
        frame_tick |-> $past(bit_tick));

endmodule

// File: tb/sbr_tick_gen_test.sv
// Directed bench for sbr_tick_gen: one task per scenario, each self-checking.
module sbr_tick_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam int SIG_OS = 0, SIG_BIT = 1, SIG_FRAME = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_presc = 2'd0;
    logic [7:0] cfg_rate = 8'd0;
    logic       cfg_ext_sel = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       ext_clk = 1'b0;
    logic       os_en, bit_tick, frame_tick;

    int  n_run = 0;
    int  n_fail = 0;
    int  cyc = 0;
    bit  ext_run = 1'b0;
    int  ext_div = 0;
    bit  done = 1'b0;

    sbr_tick_gen uut (
        .clk(clk), .rst_n(rst_n), .cfg_presc(cfg_presc), .cfg_rate(cfg_rate),
        .cfg_ext_sel(cfg_ext_sel), .cfg_wr(cfg_wr), .ext_clk(ext_clk),
        .os_en(os_en), .bit_tick(bit_tick), .frame_tick(frame_tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // External clock with a 6-cycle period while enabled.
    always @(negedge clk) begin
        if (ext_run) begin
            ext_div <= (ext_div == 2) ? 0 : ext_div + 1;
            if (ext_div == 2) ext_clk <= ~ext_clk;
        end
    end

    function automatic bit sig(input int w);
        case (w)
            SIG_OS:  return os_en;
            SIG_BIT: return bit_tick;
            default: return frame_tick;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Wait (sampling at negedge) for the selected output to be high.
    task automatic wait_high(input int w, input int limit, output int at);
        at = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (sig(w)) begin
                at = cyc;
                break;
            end
        end
    endtask

    task automatic check_period(input int w, input int exp, input int reps, input string req);
        int t0, t1;
        wait_high(w, exp + 8, t0);
        for (int r = 0; r < reps; r++) begin
            wait_high(w, exp + 8, t1);
            check(t0 >= 0 && t1 - t0 == exp, req, t1 - t0, exp);
            t0 = t1;
        end
    endtask

    task automatic apply_cfg(input logic [1:0] p, input logic [7:0] r, input bit ext, output int w_edge);
        @(negedge clk);
        cfg_presc = p; cfg_rate = r; cfg_ext_sel = ext; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        w_edge = cyc;
        check(!os_en && !bit_tick && !frame_tick, "R6 quiet after write",
              {29'd0, os_en, bit_tick, frame_tick}, 0);
    endtask

    // R1: outputs held low in reset, then chain starts from zero.
    task automatic t_reset();
        int w, t;
        rst_n = 1'b0;
        repeat (4) begin
            @(negedge clk);
            check(!os_en && !bit_tick && !frame_tick, "R1 reset low",
                  {29'd0, os_en, bit_tick, frame_tick}, 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        w = cyc;
        wait_high(SIG_OS, 10, t);
        check(t == w + 1, "R1 first os_en after release", t - w, 1);
        wait_high(SIG_BIT, 50, t);
        check(t == w + 33, "R1 first bit_tick after release", t - w, 33);
    endtask

    // R2/R3/R4/R5/R9: periods for one prescale/rate pair.
    task automatic t_periods(input logic [1:0] p, input logic [7:0] r, input bit do_bit, input bit do_frame);
        int w;
        int n;
        n = (1 << (2 * p)) * (r + 1);
        apply_cfg(p, r, 1'b0, w);
        check_period(SIG_OS, n, 3, (r == 8'd255) ? "R9 os_en period at max rate" : "R2 R3 os_en period");
        if (do_bit)   check_period(SIG_BIT, 32 * n, 2, "R4 bit_tick period");
        if (do_frame) check_period(SIG_FRAME, 320 * n, 2, "R5 frame_tick period");
    endtask

    // R6: a write mid-period restarts the chain with exact first offsets.
    task automatic t_restart();
        int w, t;
        apply_cfg(2'd1, 8'd2, 1'b0, w);
        repeat (100) @(negedge clk);
        apply_cfg(2'd2, 8'd0, 1'b0, w);
        wait_high(SIG_OS, 40, t);
        check(t == w + 16, "R6 first os_en offset", t - w, 16);
        wait_high(SIG_BIT, 600, t);
        check(t == w + 513, "R6 first bit_tick offset", t - w, 513);
        wait_high(SIG_FRAME, 5200, t);
        check(t == w + 5122, "R6 first frame_tick offset", t - w, 5122);
    endtask

    // R7: external edges drive os_en; steady pin gives nothing.
    task automatic t_external();
        int w, hits;
        ext_run = 1'b1;
        apply_cfg(2'd3, 8'd255, 1'b1, w);
        check_period(SIG_OS, 6, 3, "R7 external os_en period");
        check_period(SIG_BIT, 192, 1, "R7 external bit_tick period");
        ext_run = 1'b0;
        repeat (10) @(negedge clk);
        hits = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (os_en) hits++;
        end
        check(hits == 0, "R7 steady ext_clk gives no os_en", hits, 0);
    endtask

    // R8: internal mode ignores a toggling external pin.
    task automatic t_ext_ignored();
        int w;
        ext_run = 1'b1;
        apply_cfg(2'd0, 8'd4, 1'b0, w);
        check_period(SIG_OS, 5, 4, "R8 os_en period with ext toggling");
        check_period(SIG_BIT, 160, 1, "R8 bit_tick period with ext toggling");
        ext_run = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        check_period(SIG_OS, 1, 3, "R3 os_en steady at N=1");
        check_period(SIG_FRAME, 320, 2, "R5 frame_tick period at N=1");
        t_periods(2'd0, 8'd0, 1'b1, 1'b1);
        t_periods(2'd1, 8'd2, 1'b1, 1'b1);
        t_periods(2'd2, 8'd0, 1'b1, 1'b1);
        t_periods(2'd3, 8'd1, 1'b1, 1'b0);
        t_periods(2'd0, 8'd255, 1'b1, 1'b0);
        t_restart();
        t_external();
        t_ext_ignored();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule